// File: doc/BRIEF.md
# Strap-Latched Pad Multiplexer

This block shares one bank of 40 I/O pads among two serial ports, two parallel ports and an ISA-style expansion bus. The configuration comes from four strap pads, sampled once after reset is released and then held until the next reset. The latched value selects one of five configurations: one serial; two serial plus one parallel; two serial plus ISA; one parallel; two parallel. The routing network then connects each pad to the matching engine signal for that configuration and drives the pad output enables. Pads that the configuration does not use stay undriven.

The four strap pads also carry functions. Before capture, and while reset is asserted, every output enable is low, so the external pull resistors set the strap levels. After capture those pads act as ordinary functional pins. The decoded configuration also leaves the block as a one-hot vector, so each peripheral engine can enable itself from it.

Engine-side buses are packed. Serial inputs are `{rxd, ri_n, dsr_n, dcd_n, cts_n}` (bits 4..0) and serial outputs are `{dtr_n, rts_n, txd}`. Parallel controls are `{host_ok, dir, selin_n, init_n, autolf_n, strobe_n}` (bits 5..0) and parallel status is `{peri_ok, fault_n, select, paperend, busy, ack_n}`. ISA controls are `{a10, reset, iow_n, ior_n, cs_n[3:0], addr[2:0]}` (bits 10..0).

Top module: `strap_pinmux`

## Requirements
- R1: Reset is asynchronous and active low, and its release passes through SYNC_STAGES flops. The straps are captured on rising edge SYNC_STAGES+1 after `rst_n` rises. Until that edge, and during reset, `pad_oe` is all zero and `cfg_onehot` is zero.
- R2: The strap word {pad 33, pad 35, pad 38, pad 36} decodes as follows: 0100 gives one serial (`cfg_onehot` bit 0); 0110 gives two serial plus one parallel (bit 1); 0101 gives two serial plus ISA (bit 2); 0011 gives one parallel (bit 3); 0010 gives two parallel (bit 4).
- R3: Any other strap word selects two serial plus one parallel and raises `cfg_bad`. Otherwise `cfg_bad` is 0.
- R4: After capture, later changes on the strap pads have no effect on the configuration until the next reset.
- R5: When serial port k (k=0,1) is active, pads 8k+0..8k+4 feed `ser_in[k]` bits 0..4 and pads 8k+5..8k+7 drive `ser_out[k]` bits 0..2 with enable high. Port 0 is active in the first three configurations and port 1 in the two dual-serial ones.
- R6: In two-parallel mode, parallel port 1 uses three groups of pads.
  - Data: pads 0..7 carry data bits 0..7, with enable `par_doe[1]`.
  - Bank 8..15: pads 8..11 feed ack_n, busy, fault_n and paperend. Pads 12..15 drive selin_n, autolf_n, init_n and strobe_n.
  - Shared pads: pad 36 drives dir, pad 37 feeds peri_ok, pad 38 drives host_ok and pad 39 feeds select.
- R7: When parallel port 0 is active, it uses three groups of pads.
  - Data: pads 16..23 carry data, with enable `par_doe[0]`.
  - Bank 24..32: pads 24..28 feed busy, ack_n, paperend, select and fault_n. Pads 29..32 drive selin_n, init_n, autolf_n and strobe_n.
  - Shared pads: pad 33 drives dir, pad 34 feeds peri_ok and pad 35 drives host_ok.
- R8: In ISA mode, the ISA bus uses three groups of pads.
  - Data: pads 16..23 carry the data bus, with enable `isa_doe`.
  - Bank 24..32: pads 24..27 feed `isa_irq` bits 0..3. Pads 28..32 drive cs_n[1], a10, reset, iow_n and ior_n.
  - Shared pads: pads 33..35 drive addr[2:0], and pads 36, 38 and 39 drive cs_n[0], cs_n[2] and cs_n[3].
- R9: A pad with no function in the current configuration has output and enable at 0. Every input of an inactive engine reads 0.
- R10: After capture, strap pads act as functional pins: in a parallel configuration pad 33 is an enabled output that carries port 0's dir.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pad_i | input | 40 | Pad input levels |
| pad_o | output | 40 | Pad output values |
| pad_oe | output | 40 | Pad output enables |
| ser_out | input | 2x3 | Serial engine outputs |
| ser_in | output | 2x5 | Serial engine inputs |
| par_dout | input | 2x8 | Parallel data from engines |
| par_doe | input | 2 | Parallel data drive enables |
| par_din | output | 2x8 | Parallel data to engines |
| par_ctl | input | 2x6 | Parallel control outputs |
| par_stat | output | 2x6 | Parallel status inputs |
| isa_dout | input | 8 | ISA write data |
| isa_doe | input | 1 | ISA data drive enable |
| isa_din | output | 8 | ISA read data |
| isa_ctl | input | 11 | ISA address, selects and strobes |
| isa_irq | output | 4 | ISA interrupt requests |
| cfg_onehot | output | 5 | Decoded configuration, one-hot |
| cfg_bad | output | 1 | Strap word was not a legal code |

## Verification
The bench builds the block with SYNC_STAGES set to 3 instead of the default 2. This shows that the capture edge follows the synchronizer depth and is not fixed at two cycles. With this setting, the bench can sample the output enables one cycle before capture and again right after it. Each of the five legal strap codes, plus two illegal ones, gets its own reset. This covers every routing branch and the fallback path.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;
  localparam int NPAD      = 40;
  localparam int STRAP_W   = 4;
  localparam int NCFG      = 5;
  localparam int BYTE_W    = 8;
  localparam int SP_IN_W   = 5;
  localparam int SP_OUT_W  = 3;
  localparam int PP_CTL_W  = 6;
  localparam int PP_STAT_W = 6;
  localparam int ISA_CTL_W = 11;
  localparam int NIRQ      = 4;
  localparam int NSP       = 2;
  localparam int NPP       = 2;

  // pad bank bases
  localparam int BANK_S0 = 0;
  localparam int BANK_S1 = 8;
  localparam int BANK_D  = 16;
  localparam int BANK_C  = 24;
  localparam int BANK_X  = 33;

  // strap pad positions, strap bit 3 down to 0
  localparam int STRAP_PAD3 = BANK_X + 0;
  localparam int STRAP_PAD2 = BANK_X + 2;
  localparam int STRAP_PAD1 = BANK_X + 5;
  localparam int STRAP_PAD0 = BANK_X + 3;

  // parallel control fields
  localparam int CT_STB = 0, CT_ALF = 1, CT_INIT = 2, CT_SELIN = 3, CT_DIR = 4, CT_HOST = 5;
  // parallel status fields
  localparam int ST_ACK = 0, ST_BUSY = 1, ST_PEND = 2, ST_SEL = 3, ST_FAULT = 4, ST_PERI = 5;
  // isa control fields
  localparam int IC_ADDR = 0, IC_CS = 3, IC_IOR = 7, IC_IOW = 8, IC_RST = 9, IC_A10 = 10;

  typedef enum logic [2:0] {
    CFG_1S    = 3'd0,
    CFG_2S1P  = 3'd1,
    CFG_2SISA = 3'd2,
    CFG_1P    = 3'd3,
    CFG_2P    = 3'd4
  } cfg_e;

  localparam logic [STRAP_W-1:0] CODE_1S    = 4'b0100;
  localparam logic [STRAP_W-1:0] CODE_2S1P  = 4'b0110;
  localparam logic [STRAP_W-1:0] CODE_2SISA = 4'b0101;
  localparam logic [STRAP_W-1:0] CODE_1P    = 4'b0011;
  localparam logic [STRAP_W-1:0] CODE_2P    = 4'b0010;
endpackage

// File: rtl/pm_rst_sync.sv
module pm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = (sync_q << 1) | {{(STAGES-1){1'b0}}, 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/pm_strap_latch.sv
module pm_strap_latch
  import pinmux_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [STRAP_W-1:0] strap_i,
  output logic [NCFG-1:0]    cfg_onehot,
  output logic               cfg_bad
);
  logic               taken_q, taken_d;
  logic [STRAP_W-1:0] strap_q, strap_d;
  cfg_e               cfg;
  logic               illegal;

  // next state: load once, then hold
  always_comb begin
    taken_d = taken_q;
    strap_d = strap_q;
    if (!taken_q) begin
      taken_d = 1'b1;
      strap_d = strap_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      taken_q <= 1'b0;
      strap_q <= '0;
    end else begin
      taken_q <= taken_d;
      strap_q <= strap_d;
    end
  end

  always_comb begin
    illegal = 1'b0;
    unique case (strap_q)
      CODE_1S:    cfg = CFG_1S;
      CODE_2S1P:  cfg = CFG_2S1P;
      CODE_2SISA: cfg = CFG_2SISA;
      CODE_1P:    cfg = CFG_1P;
      CODE_2P:    cfg = CFG_2P;
      default: begin
        cfg     = CFG_2S1P;
        illegal = 1'b1;
      end
    endcase
  end

  always_comb begin
    cfg_onehot = '0;
    if (taken_q) begin
      cfg_onehot[0] = (cfg == CFG_1S);
      cfg_onehot[1] = (cfg == CFG_2S1P);
      cfg_onehot[2] = (cfg == CFG_2SISA);
      cfg_onehot[3] = (cfg == CFG_1P);
      cfg_onehot[4] = (cfg == CFG_2P);
    end
  end

  assign cfg_bad = taken_q & illegal;

  // R2
  cfg_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_onehot != '0) |-> ($countones(cfg_onehot) == 1));
  // R4
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_onehot != '0) |=> $stable(cfg_onehot) && $stable(cfg_bad));
  // R3
  bad_fallback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_bad |-> cfg_onehot[CFG_2S1P]);
endmodule

// File: rtl/pm_pad_route.sv
module pm_pad_route
  import pinmux_pkg::*;
(
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [NCFG-1:0]                    cfg_onehot,
  input  logic [NPAD-1:0]                    pad_i,
  output logic [NPAD-1:0]                    pad_o,
  output logic [NPAD-1:0]                    pad_oe,
  input  logic [NSP-1:0][SP_OUT_W-1:0]       ser_out,
  output logic [NSP-1:0][SP_IN_W-1:0]        ser_in,
  input  logic [NPP-1:0][BYTE_W-1:0]         par_dout,
  input  logic [NPP-1:0]                     par_doe,
  output logic [NPP-1:0][BYTE_W-1:0]         par_din,
  input  logic [NPP-1:0][PP_CTL_W-1:0]       par_ctl,
  output logic [NPP-1:0][PP_STAT_W-1:0]      par_stat,
  input  logic [BYTE_W-1:0]                  isa_dout,
  input  logic                               isa_doe,
  output logic [BYTE_W-1:0]                  isa_din,
  input  logic [ISA_CTL_W-1:0]               isa_ctl,
  output logic [NIRQ-1:0]                    isa_irq
);
  logic fn_sp0, fn_sp1, fn_pp0, fn_pp1, fn_isa;
  logic unused_pads;

  assign fn_sp0 = cfg_onehot[CFG_1S] | cfg_onehot[CFG_2S1P] | cfg_onehot[CFG_2SISA];
  assign fn_sp1 = cfg_onehot[CFG_2S1P] | cfg_onehot[CFG_2SISA];
  assign fn_pp0 = cfg_onehot[CFG_2S1P] | cfg_onehot[CFG_1P] | cfg_onehot[CFG_2P];
  assign fn_pp1 = cfg_onehot[CFG_2P];
  assign fn_isa = cfg_onehot[CFG_2SISA];

  // pads that are outputs in every role they take
  assign unused_pads = ^{pad_i[BANK_S1+5 +: 3], pad_i[BANK_C+5 +: 4],
                         pad_i[BANK_X], pad_i[BANK_X+2], pad_i[BANK_X+3], pad_i[BANK_X+5]};

  always_comb begin
    pad_o    = '0;
    pad_oe   = '0;
    ser_in   = '0;
    par_din  = '0;
    par_stat = '0;
    isa_din  = '0;
    isa_irq  = '0;

    // bank S0: serial port 0, or data of parallel port 1
    if (fn_sp0) begin
      ser_in[0]                               = pad_i[BANK_S0 +: SP_IN_W];
      pad_o[BANK_S0+SP_IN_W +: SP_OUT_W]      = ser_out[0];
      pad_oe[BANK_S0+SP_IN_W +: SP_OUT_W]     = '1;
    end else if (fn_pp1) begin
      par_din[1]                    = pad_i[BANK_S0 +: BYTE_W];
      pad_o[BANK_S0 +: BYTE_W]      = par_dout[1];
      pad_oe[BANK_S0 +: BYTE_W]     = {BYTE_W{par_doe[1]}};
    end

    // bank S1: serial port 1, or handshake of parallel port 1
    if (fn_sp1) begin
      ser_in[1]                               = pad_i[BANK_S1 +: SP_IN_W];
      pad_o[BANK_S1+SP_IN_W +: SP_OUT_W]      = ser_out[1];
      pad_oe[BANK_S1+SP_IN_W +: SP_OUT_W]     = '1;
    end else if (fn_pp1) begin
      par_stat[1][ST_ACK]   = pad_i[BANK_S1+0];
      par_stat[1][ST_BUSY]  = pad_i[BANK_S1+1];
      par_stat[1][ST_FAULT] = pad_i[BANK_S1+2];
      par_stat[1][ST_PEND]  = pad_i[BANK_S1+3];
      pad_o[BANK_S1+4]      = par_ctl[1][CT_SELIN];
      pad_o[BANK_S1+5]      = par_ctl[1][CT_ALF];
      pad_o[BANK_S1+6]      = par_ctl[1][CT_INIT];
      pad_o[BANK_S1+7]      = par_ctl[1][CT_STB];
      pad_oe[BANK_S1+4 +: 4] = '1;
    end

    // data bank: parallel port 0 or ISA bus
    if (fn_pp0) begin
      par_din[0]               = pad_i[BANK_D +: BYTE_W];
      pad_o[BANK_D +: BYTE_W]  = par_dout[0];
      pad_oe[BANK_D +: BYTE_W] = {BYTE_W{par_doe[0]}};
    end else if (fn_isa) begin
      isa_din                  = pad_i[BANK_D +: BYTE_W];
      pad_o[BANK_D +: BYTE_W]  = isa_dout;
      pad_oe[BANK_D +: BYTE_W] = {BYTE_W{isa_doe}};
    end

    // control bank and first shared pads
    if (fn_pp0) begin
      par_stat[0][ST_BUSY]  = pad_i[BANK_C+0];
      par_stat[0][ST_ACK]   = pad_i[BANK_C+1];
      par_stat[0][ST_PEND]  = pad_i[BANK_C+2];
      par_stat[0][ST_SEL]   = pad_i[BANK_C+3];
      par_stat[0][ST_FAULT] = pad_i[BANK_C+4];
      pad_o[BANK_C+5]       = par_ctl[0][CT_SELIN];
      pad_o[BANK_C+6]       = par_ctl[0][CT_INIT];
      pad_o[BANK_C+7]       = par_ctl[0][CT_ALF];
      pad_o[BANK_C+8]       = par_ctl[0][CT_STB];
      pad_oe[BANK_C+5 +: 4] = '1;
      pad_o[BANK_X+0]       = par_ctl[0][CT_DIR];
      pad_oe[BANK_X+0]      = 1'b1;
      par_stat[0][ST_PERI]  = pad_i[BANK_X+1];
      pad_o[BANK_X+2]       = par_ctl[0][CT_HOST];
      pad_oe[BANK_X+2]      = 1'b1;
    end else if (fn_isa) begin
      isa_irq               = pad_i[BANK_C +: NIRQ];
      pad_o[BANK_C+4]       = isa_ctl[IC_CS+1];
      pad_o[BANK_C+5]       = isa_ctl[IC_A10];
      pad_o[BANK_C+6]       = isa_ctl[IC_RST];
      pad_o[BANK_C+7]       = isa_ctl[IC_IOW];
      pad_o[BANK_C+8]       = isa_ctl[IC_IOR];
      pad_oe[BANK_C+4 +: 5] = '1;
      pad_o[BANK_X +: 3]    = isa_ctl[IC_ADDR +: 3];
      pad_oe[BANK_X +: 3]   = '1;
      pad_o[BANK_X+3]       = isa_ctl[IC_CS+0];
      pad_o[BANK_X+5]       = isa_ctl[IC_CS+2];
      pad_o[BANK_X+6]       = isa_ctl[IC_CS+3];
      pad_oe[BANK_X+3]      = 1'b1;
      pad_oe[BANK_X+5]      = 1'b1;
      pad_oe[BANK_X+6]      = 1'b1;
    end

    // remaining shared pads: parallel port 1 sideband
    if (fn_pp1) begin
      pad_o[BANK_X+3]      = par_ctl[1][CT_DIR];
      pad_oe[BANK_X+3]     = 1'b1;
      par_stat[1][ST_PERI] = pad_i[BANK_X+4];
      pad_o[BANK_X+5]      = par_ctl[1][CT_HOST];
      pad_oe[BANK_X+5]     = 1'b1;
      par_stat[1][ST_SEL]  = pad_i[BANK_X+6];
    end
  end

  // R1
  no_drive_before_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_onehot == '0) |-> (pad_oe == '0));
  // R9
  single_serial_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_onehot[CFG_1S] |-> (pad_oe[NPAD-1:BANK_S1] == '0));
  // R6
  dual_par_no_serial_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_onehot[CFG_2P] |-> (ser_in == '0));
  // R8
  isa_no_par0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_onehot[CFG_2SISA] |-> (par_din[0] == '0 && par_stat[0] == '0));
endmodule

// File: rtl/strap_pinmux.sv
module strap_pinmux
  import pinmux_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NPAD-1:0]               pad_i,
  output logic [NPAD-1:0]               pad_o,
  output logic [NPAD-1:0]               pad_oe,
  input  logic [NSP-1:0][SP_OUT_W-1:0]  ser_out,
  output logic [NSP-1:0][SP_IN_W-1:0]   ser_in,
  input  logic [NPP-1:0][BYTE_W-1:0]    par_dout,
  input  logic [NPP-1:0]                par_doe,
  output logic [NPP-1:0][BYTE_W-1:0]    par_din,
  input  logic [NPP-1:0][PP_CTL_W-1:0]  par_ctl,
  output logic [NPP-1:0][PP_STAT_W-1:0] par_stat,
  input  logic [BYTE_W-1:0]             isa_dout,
  input  logic                          isa_doe,
  output logic [BYTE_W-1:0]             isa_din,
  input  logic [ISA_CTL_W-1:0]          isa_ctl,
  output logic [NIRQ-1:0]               isa_irq,
  output logic [NCFG-1:0]               cfg_onehot,
  output logic                          cfg_bad
);
  logic               srst_n;
  logic [STRAP_W-1:0] strap_w;

  assign strap_w = {pad_i[STRAP_PAD3], pad_i[STRAP_PAD2], pad_i[STRAP_PAD1], pad_i[STRAP_PAD0]};

  pm_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  pm_strap_latch u_latch (
    .clk        (clk),
    .rst_n      (srst_n),
    .strap_i    (strap_w),
    .cfg_onehot (cfg_onehot),
    .cfg_bad    (cfg_bad)
  );

  pm_pad_route u_route (
    .clk        (clk),
    .rst_n      (srst_n),
    .cfg_onehot (cfg_onehot),
    .pad_i      (pad_i),
    .pad_o      (pad_o),
    .pad_oe     (pad_oe),
    .ser_out    (ser_out),
    .ser_in     (ser_in),
    .par_dout   (par_dout),
    .par_doe    (par_doe),
    .par_din    (par_din),
    .par_ctl    (par_ctl),
    .par_stat   (par_stat),
    .isa_dout   (isa_dout),
    .isa_doe    (isa_doe),
    .isa_din    (isa_din),
    .isa_ctl    (isa_ctl),
    .isa_irq    (isa_irq)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (pad_oe == '0));
endmodule

// File: tb/strap_pinmux_test.sv
module strap_pinmux_test;
  localparam int STG = 3;
  localparam int WD_CYCLES = 200000;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [39:0]      pad_i;
  logic [39:0]      pad_o, pad_oe;
  logic [1:0][2:0]  ser_out;
  logic [1:0][4:0]  ser_in;
  logic [1:0][7:0]  par_dout;
  logic [1:0]       par_doe;
  logic [1:0][7:0]  par_din;
  logic [1:0][5:0]  par_ctl;
  logic [1:0][5:0]  par_stat;
  logic [7:0]       isa_dout;
  logic             isa_doe;
  logic [7:0]       isa_din;
  logic [10:0]      isa_ctl;
  logic [3:0]       isa_irq;
  logic [4:0]       cfg_onehot;
  logic             cfg_bad;

  int nchk = 0;
  int nerr = 0;

  always #10 clk = ~clk;

  strap_pinmux #(.SYNC_STAGES(STG)) uut (
    .clk(clk), .rst_n(rst_n), .pad_i(pad_i), .pad_o(pad_o), .pad_oe(pad_oe),
    .ser_out(ser_out), .ser_in(ser_in), .par_dout(par_dout), .par_doe(par_doe),
    .par_din(par_din), .par_ctl(par_ctl), .par_stat(par_stat), .isa_dout(isa_dout),
    .isa_doe(isa_doe), .isa_din(isa_din), .isa_ctl(isa_ctl), .isa_irq(isa_irq),
    .cfg_onehot(cfg_onehot), .cfg_bad(cfg_bad)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put_straps(input logic [3:0] s);
    pad_i[33] = s[3];
    pad_i[35] = s[2];
    pad_i[38] = s[1];
    pad_i[36] = s[0];
  endtask

  task automatic settle;
    @(negedge clk);
    #1;
  endtask

  // reset, strap capture timing, decode and hold
  task automatic boot(input logic [3:0] s, input logic [4:0] exp_oh, input logic exp_bad);
    @(negedge clk);
    rst_n = 1'b0;
    pad_i = '0; ser_out = '0; par_dout = '0; par_doe = '0; par_ctl = '0;
    isa_dout = '0; isa_doe = '0; isa_ctl = '0;
    put_straps(s);
    repeat (2) @(negedge clk);
    #1;
    chk("R1 oe during reset", pad_oe, 0);
    chk("R1 cfg during reset", cfg_onehot, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (STG) @(negedge clk);
    #1;
    chk("R1 oe before capture", pad_oe, 0);
    chk("R1 cfg before capture", cfg_onehot, 0);
    settle();
    chk("R2 decoded cfg", cfg_onehot, exp_oh);
    chk("R3 bad flag", cfg_bad, exp_bad);
    put_straps(~s);
    repeat (3) @(negedge clk);
    #1;
    chk("R4 cfg held after strap change", cfg_onehot, exp_oh);
    chk("R4 bad flag held", cfg_bad, exp_bad);
  endtask

  task automatic t_one_serial;
    boot(4'b0100, 5'b00001, 1'b0);
    ser_out[0] = 3'b101;
    pad_i = '1;
    pad_i[4:0] = 5'b10110;
    settle();
    chk("R5 sp0 out pads", pad_o[7:5], 3'b101);
    chk("R5 sp0 oe", pad_oe[7:0], 8'hE0);
    chk("R5 sp0 inputs", ser_in[0], 5'b10110);
    chk("R9 upper pads idle oe", pad_oe[39:8], 0);
    chk("R9 upper pads idle out", pad_o[39:8], 0);
    chk("R9 sp1 inputs zero", ser_in[1], 0);
    chk("R9 parallel inputs zero", {par_din, par_stat}, 0);
    chk("R9 isa inputs zero", {isa_din, isa_irq}, 0);
  endtask

  task automatic t_two_serial_par;
    boot(4'b0110, 5'b00010, 1'b0);
    ser_out[1] = 3'b011;
    pad_i[12:8] = 5'b01101;
    par_dout[0] = 8'hA5;
    par_doe[0] = 1'b1;
    pad_i[23:16] = 8'h3C;
    par_ctl[0] = 6'b101001;
    pad_i[28:24] = 5'b01101;
    pad_i[34] = 1'b1;
    settle();
    chk("R5 sp1 out pads", pad_o[15:13], 3'b011);
    chk("R5 sp1 oe", pad_oe[15:8], 8'hE0);
    chk("R5 sp1 inputs", ser_in[1], 5'b01101);
    chk("R7 pp0 data out", pad_o[23:16], 8'hA5);
    chk("R7 pp0 data oe", pad_oe[23:16], 8'hFF);
    chk("R7 pp0 data in", par_din[0], 8'h3C);
    chk("R7 pp0 ctl pads 32..29", pad_o[32:29], 4'b1001);
    chk("R7 pp0 host pad35", pad_o[35], 1'b1);
    chk("R7 pp0 status", par_stat[0], 6'b101110);
    chk("R7 ctl bank oe", pad_oe[32:24], 9'b1_1110_0000);
    chk("R10 pad33 dir enabled", {pad_oe[33], pad_o[33]}, 2'b10);
    chk("R9 pads 36..39 idle", pad_oe[39:36], 0);
    chk("R9 pp1 and isa inputs zero", {par_stat[1], par_din[1], isa_irq, isa_din}, 0);
    par_doe[0] = 1'b0;
    settle();
    chk("R7 pp0 data released", pad_oe[23:16], 8'h00);
  endtask

  task automatic t_isa;
    boot(4'b0101, 5'b00100, 1'b0);
    isa_dout = 8'h5A;
    isa_doe = 1'b1;
    pad_i[23:16] = 8'hC3;
    pad_i[27:24] = 4'b1001;
    isa_ctl = 11'b1_0_1_0_1010_110;
    settle();
    chk("R8 isa data out", pad_o[23:16], 8'h5A);
    chk("R8 isa data oe", pad_oe[23:16], 8'hFF);
    chk("R8 isa data in", isa_din, 8'hC3);
    chk("R8 isa irq", isa_irq, 4'b1001);
    chk("R8 isa ctl pads 32..28", pad_o[32:28], 5'b01011);
    chk("R8 isa addr pads", pad_o[35:33], 3'b110);
    chk("R8 isa cs pads 39,38,36", {pad_o[39], pad_o[38], pad_o[36]}, 3'b100);
    chk("R8 isa oe 39..24", pad_oe[39:24], 16'hDFF0);
    chk("R5 both serial oe", pad_oe[15:0], 16'hE0E0);
    chk("R9 pp0 inputs zero in isa", {par_din[0], par_stat[0]}, 0);
  endtask

  task automatic t_one_par;
    boot(4'b0011, 5'b01000, 1'b0);
    pad_i[15:0] = 16'hFFFF;
    par_dout[0] = 8'h0F;
    par_doe[0] = 1'b1;
    settle();
    chk("R9 serial pads idle", pad_oe[15:0], 0);
    chk("R9 serial inputs zero", ser_in, 0);
    chk("R7 pp0 data out", pad_o[23:16], 8'h0F);
    chk("R9 pads 36..39 idle", pad_oe[39:36], 0);
    chk("R9 pp1 inputs zero", {par_din[1], par_stat[1]}, 0);
  endtask

  task automatic t_two_par;
    boot(4'b0010, 5'b10000, 1'b0);
    par_dout[1] = 8'h96;
    par_doe[1] = 1'b1;
    pad_i[7:0] = 8'h69;
    pad_i[11:8] = 4'b1011;
    pad_i[37] = 1'b1;
    pad_i[39] = 1'b0;
    par_ctl[1] = 6'b010110;
    settle();
    chk("R6 pp1 data out", pad_o[7:0], 8'h96);
    chk("R6 pp1 data oe", pad_oe[7:0], 8'hFF);
    chk("R6 pp1 data in", par_din[1], 8'h69);
    chk("R6 pp1 status", par_stat[1], 6'b100111);
    chk("R6 pp1 ctl pads 15..12", pad_o[15:12], 4'b0110);
    chk("R6 bank oe", pad_oe[15:8], 8'hF0);
    chk("R6 sideband out", {pad_o[38], pad_o[36]}, 2'b01);
    chk("R6 sideband oe", pad_oe[39:36], 4'b0101);
    chk("R9 serial inputs zero", ser_in, 0);
    chk("R10 pad33 dir enabled", pad_oe[33], 1'b1);
  endtask

  task automatic t_bad;
    boot(4'b1111, 5'b00010, 1'b1);
    par_doe[0] = 1'b1;
    settle();
    chk("R3 fallback routes pp0", pad_oe[23:16], 8'hFF);
    chk("R3 fallback routes sp1", pad_oe[15:8], 8'hE0);
    boot(4'b0000, 5'b00010, 1'b1);
  endtask

  initial begin
    rst_n = 1'b0;
    pad_i = '0; ser_out = '0; par_dout = '0; par_doe = '0; par_ctl = '0;
    isa_dout = '0; isa_doe = '0; isa_ctl = '0;
    t_one_serial();
    t_two_serial_par();
    t_isa();
    t_one_par();
    t_two_par();
    t_bad();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    nchk++;
    nerr++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule